// File: doc/BRIEF.md
# Soft-Start and Protection Sequencer

This block is the supervisory state machine of a two-phase step-down regulator controller. It qualifies the supplies and clamps the output low before start-up. It then ramps the regulation reference from zero to the programmed code over a fixed number of switching periods. Once the reference is high enough it arms the under-voltage comparator, and it raises power-good when the ramp completes. Every analog threshold is resolved outside the block and arrives as a one-bit flag, and the switching-period boundary arrives as a single-cycle tick.

Over- and under-voltage faults are latched. An over-voltage fault holds the low-side switches on as a crowbar. An under-voltage fault turns every switch off. Either fault is cleared only when the main supply flag drops, which models a power cycle. The inhibit input is different: it shuts the stage down and suspends protection, and releasing it restarts the whole sequence from the beginning.

Top module: `softstart_seq`

## Requirements
- R1: After reset, refCode is 0 and switchEn, lsForce, pgood, pgCmpEn, uvCmpEn and fault are all low.
- R2: When the block is stopped with no fault and no inhibit, clampOk high makes lsForce go high at the next clock edge while switchEn stays low. clampOk going low in that clamp phase drops lsForce at the next edge.
- R3: The ramp starts only from the clamp phase, and only when mainOk and drvOk are both high. Switching is then enabled (switchEn high) and lsForce is released at the same edge. switchEn and lsForce are never high together.
- R4: During the ramp, refCode equals floor(targetCode * n / 2^RAMP_BITS), where n is the number of cycleTick pulses seen since the ramp began. Cycles without a tick leave refCode unchanged.
- R5: The edge that brings the 2^RAMP_BITS-th tick enters run. In run, refCode equals targetCode and pgood and pgCmpEn are high. pgood is low in every other phase.
- R6: During the ramp, uvCmpEn is high exactly when refCode >= UV_EN_CODE. It is high throughout run. uvDet has no effect while uvCmpEn is low.
- R7: uvDet sampled high while uvCmpEn is high enters the under-voltage fault at the next edge. In that fault, fault is high, switchEn and lsForce are low, and refCode is 0.
- R8: ovDet high in the clamp, ramp or run phase enters the over-voltage fault at the next edge. In that fault, fault and lsForce are high and switchEn is low. ovDet takes precedence over uvDet.
- R9: A fault stays latched while mainOk is high, whatever inhibit, ovDet, uvDet or drvOk do. mainOk low clears it at the next edge, and the block returns to the stopped state with fault low.
- R10: mainOk or drvOk going low during the ramp or run stops the block at the next edge with no fault. The clamp is then re-entered if clampOk is still high.
- R11: Outside a fault, inhibit high at an edge turns every switch off, drops pgood and ignores ovDet and uvDet. Releasing inhibit returns the block to the stopped state, and the next start ramps again from refCode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mainOk | input | 1 | Main supply above its turn-on threshold |
| drvOk | input | 1 | Driver supply above its turn-on threshold |
| clampOk | input | 1 | Driver supply above the low pre-clamp threshold |
| inhibit | input | 1 | Shutdown request (level) |
| ovDet | input | 1 | Over-voltage comparator result |
| uvDet | input | 1 | Under-voltage comparator result |
| cycleTick | input | 1 | One-cycle pulse per switching period |
| targetCode | input | REF_W | Programmed reference code |
| refCode | output | REF_W | Ramped reference to the error amplifier |
| switchEn | output | 1 | PWM switching of both phases enabled |
| lsForce | output | 1 | Force both low-side switches on |
| pgood | output | 1 | Power-good indication |
| fault | output | 1 | Latched protection fault |
| pgCmpEn | output | 1 | Power-good comparator enable |
| uvCmpEn | output | 1 | Under-voltage comparator enable |

## Verification
The assertions assume that targetCode changes only while it is not being ramped toward. The monotonic-ramp check is therefore qualified by a stable target, and the stimulus changes the target only while the block is stopped. They also assume that the comparator flags are plain levels, sampled at clock edges. The bench sweeps every ramp step for two target codes. It applies uvDet both before and after the arming point, and it raises ovDet together with uvDet to exercise precedence. It also holds inhibit, fault-clearing attempts and supply drops for whole cycles, so that each phase change falls on a known edge.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_CLAMP = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_OVF   = 3'd4,
    ST_UVF   = 3'd5,
    ST_INH   = 3'd6
  } seqState_t;

  // strobes from control to the ramp datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } rampCtl_t;

endpackage

// File: rtl/ssq_ramp.sv
module ssq_ramp
  import ssq_pkg::*;
#(
  parameter int REF_W      = 8,
  parameter int RAMP_BITS  = 11,
  parameter int UV_EN_CODE = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  rampCtl_t         ctl,
  input  logic [REF_W-1:0] targetCode,
  output logic [REF_W-1:0] refCode,
  output logic             rampLast,
  output logic             uvGate
);

  localparam int CNT_W  = RAMP_BITS + 1;
  localparam int PROD_W = REF_W + CNT_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RAMP_BITS;

  logic [CNT_W-1:0]  stepCnt;
  logic [PROD_W-1:0] scaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (ctl.cntClear) begin
      stepCnt <= '0;
    end else if (ctl.cntStep && (stepCnt != FULL)) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    scaled   = PROD_W'(targetCode) * PROD_W'(stepCnt);
    refCode  = REF_W'(scaled >> RAMP_BITS);
    rampLast = (stepCnt == FULL - 1'b1);
    uvGate   = (refCode >= REF_W'(UV_EN_CODE));
  end

endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     mainOk,
  input  logic     drvOk,
  input  logic     clampOk,
  input  logic     inhibit,
  input  logic     ovDet,
  input  logic     uvDet,
  input  logic     cycleTick,
  input  logic     rampLast,
  input  logic     uvGate,
  output rampCtl_t ctl,
  output logic     switchEn,
  output logic     lsForce,
  output logic     pgood,
  output logic     fault,
  output logic     pgCmpEn,
  output logic     uvCmpEn
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    uvCmpEn = ((state == ST_RAMP) && uvGate) || (state == ST_RUN);
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_OFF: begin
        if (inhibit)      nextState = ST_INH;
        else if (clampOk) nextState = ST_CLAMP;
      end
      ST_CLAMP: begin
        if (inhibit)               nextState = ST_INH;
        else if (ovDet)            nextState = ST_OVF;
        else if (!clampOk)         nextState = ST_OFF;
        else if (mainOk && drvOk)  nextState = ST_RAMP;
      end
      ST_RAMP, ST_RUN: begin
        if (inhibit)                  nextState = ST_INH;
        else if (ovDet)               nextState = ST_OVF;
        else if (uvDet && uvCmpEn)    nextState = ST_UVF;
        else if (!mainOk || !drvOk)   nextState = ST_OFF;
        else if ((state == ST_RAMP) && cycleTick && rampLast)
                                      nextState = ST_RUN;
      end
      ST_OVF, ST_UVF: begin
        if (!mainOk) nextState = ST_OFF;
      end
      ST_INH: begin
        if (!inhibit) nextState = ST_OFF;
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_comb begin
    ctl.cntClear = (nextState != ST_RAMP) && (nextState != ST_RUN);
    ctl.cntStep  = (state == ST_RAMP) && cycleTick &&
                   ((nextState == ST_RAMP) || (nextState == ST_RUN));
    switchEn = (state == ST_RAMP) || (state == ST_RUN);
    lsForce  = (state == ST_CLAMP) || (state == ST_OVF);
    fault    = (state == ST_OVF) || (state == ST_UVF);
    pgCmpEn  = (state == ST_RUN);
    pgood    = (state == ST_RUN);
  end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ssq_pkg::*;
#(
  parameter int REF_W      = 8,
  parameter int RAMP_BITS  = 11,
  parameter int UV_EN_CODE = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mainOk,
  input  logic             drvOk,
  input  logic             clampOk,
  input  logic             inhibit,
  input  logic             ovDet,
  input  logic             uvDet,
  input  logic             cycleTick,
  input  logic [REF_W-1:0] targetCode,
  output logic [REF_W-1:0] refCode,
  output logic             switchEn,
  output logic             lsForce,
  output logic             pgood,
  output logic             fault,
  output logic             pgCmpEn,
  output logic             uvCmpEn
);

  rampCtl_t rampCtl;
  logic     rampLast;
  logic     uvGate;

  ssq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mainOk(mainOk), .drvOk(drvOk),
    .clampOk(clampOk), .inhibit(inhibit), .ovDet(ovDet), .uvDet(uvDet),
    .cycleTick(cycleTick), .rampLast(rampLast), .uvGate(uvGate),
    .ctl(rampCtl), .switchEn(switchEn), .lsForce(lsForce), .pgood(pgood),
    .fault(fault), .pgCmpEn(pgCmpEn), .uvCmpEn(uvCmpEn)
  );

  ssq_ramp #(
    .REF_W(REF_W), .RAMP_BITS(RAMP_BITS), .UV_EN_CODE(UV_EN_CODE)
  ) u_ramp (
    .clk(clk), .rstN(rstN), .ctl(rampCtl), .targetCode(targetCode),
    .refCode(refCode), .rampLast(rampLast), .uvGate(uvGate)
  );

endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
  parameter int REF_W      = 8,
  parameter int UV_EN_CODE = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             mainOk,
  input logic             inhibit,
  input logic [REF_W-1:0] targetCode,
  input logic [REF_W-1:0] refCode,
  input logic             switchEn,
  input logic             lsForce,
  input logic             pgood,
  input logic             fault,
  input logic             pgCmpEn,
  input logic             uvCmpEn
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(switchEn && lsForce)); // R3

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    refCode <= targetCode); // R4

  AST_RAMP_MONO: assert property (@(posedge clk) disable iff (!rstN)
    (switchEn && $past(switchEn) && $stable(targetCode)) |-> (refCode >= $past(refCode))); // R4

  AST_PGOOD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> (refCode == targetCode)); // R5

  AST_UV_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (uvCmpEn && !pgCmpEn) |-> (refCode >= REF_W'(UV_EN_CODE))); // R6

  AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!switchEn && !pgood)); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fault && mainOk) |=> fault); // R9

  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && !fault) |=> (!switchEn && !lsForce && !fault)); // R11

endmodule

bind softstart_seq ssq_checker #(.REF_W(REF_W), .UV_EN_CODE(UV_EN_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .mainOk(mainOk), .inhibit(inhibit),
  .targetCode(targetCode), .refCode(refCode), .switchEn(switchEn),
  .lsForce(lsForce), .pgood(pgood), .fault(fault), .pgCmpEn(pgCmpEn),
  .uvCmpEn(uvCmpEn)
);

// File: tb/softstart_seq_test.sv
module softstart_seq_test;

  localparam int REF_W = 8;
  localparam int RAMP_BITS = 11;
  localparam int UV_EN_CODE = 128;
  localparam int STEPS = 1 << RAMP_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainOk = 1'b0, drvOk = 1'b0, clampOk = 1'b0, inhibit = 1'b0;
  logic ovDet = 1'b0, uvDet = 1'b0, cycleTick = 1'b0;
  logic [REF_W-1:0] targetCode = 8'd200;
  logic [REF_W-1:0] refCode;
  logic switchEn, lsForce, pgood, fault, pgCmpEn, uvCmpEn;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  softstart_seq #(.REF_W(REF_W), .RAMP_BITS(RAMP_BITS), .UV_EN_CODE(UV_EN_CODE)) uut (
    .clk(clk), .rstN(rstN), .mainOk(mainOk), .drvOk(drvOk), .clampOk(clampOk),
    .inhibit(inhibit), .ovDet(ovDet), .uvDet(uvDet), .cycleTick(cycleTick),
    .targetCode(targetCode), .refCode(refCode), .switchEn(switchEn),
    .lsForce(lsForce), .pgood(pgood), .fault(fault), .pgCmpEn(pgCmpEn),
    .uvCmpEn(uvCmpEn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rampVal(input int tgt, input int n);
    return (tgt * n) / STEPS;
  endfunction

  // outputs packed as {switchEn, lsForce, fault, pgood}
  function automatic int ctrlBits();
    return {28'd0, switchEn, lsForce, fault, pgood};
  endfunction

  task automatic sweepRamp(input int tgt, input bit withPulses);
    for (int k = 1; k < STEPS; k++) begin
      @(negedge clk);
      chk("R4 ramp value", refCode, rampVal(tgt, k));
      chk("R6 uv enable", uvCmpEn, (rampVal(tgt, k) >= UV_EN_CODE) ? 1 : 0);
      chk("R5 pgood low in ramp", pgood, 0);
      if (withPulses && k == 100) uvDet = 1'b1;
      if (withPulses && k == 101) begin
        uvDet = 1'b0;
        chk("R6 uvDet ignored while disarmed", switchEn, 1);
      end
      if (withPulses && k == 500) begin
        cycleTick = 1'b0;
        for (int p = 0; p < 3; p++) begin
          @(negedge clk);
          chk("R4 hold without tick", refCode, rampVal(tgt, 500));
        end
        cycleTick = 1'b1;
      end
    end
    @(negedge clk);
    chk("R5 run ref", refCode, tgt);
    chk("R5 pgood", pgood, 1);
    chk("R5 pg comparator", pgCmpEn, 1);
    chk("R6 uv armed in run", uvCmpEn, 1);
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset ctrl", ctrlBits(), 0);
    chk("R1 reset ref", refCode, 0);
    chk("R1 reset enables", {pgCmpEn, uvCmpEn}, 0);

    mainOk = 1'b1;
    @(negedge clk);
    chk("R3 no start without clamp", ctrlBits(), 0);

    clampOk = 1'b1;
    @(negedge clk);
    chk("R2 clamp on", ctrlBits(), 4'b0100);
    clampOk = 1'b0;
    @(negedge clk);
    chk("R2 clamp released", ctrlBits(), 0);
    clampOk = 1'b1;
    @(negedge clk);
    chk("R2 clamp again", ctrlBits(), 4'b0100);
    @(negedge clk);
    chk("R3 wait for drvOk", ctrlBits(), 4'b0100);

    drvOk = 1'b1;
    @(negedge clk);
    chk("R3 ramp start", ctrlBits(), 4'b1000);
    chk("R3 ramp from zero", refCode, 0);
    cycleTick = 1'b1;
    sweepRamp(200, 1'b1);

    // under-voltage fault in run
    uvDet = 1'b1;
    @(negedge clk);
    chk("R7 uv fault", ctrlBits(), 4'b0010);
    chk("R7 ref zero", refCode, 0);
    uvDet = 1'b0; inhibit = 1'b1; drvOk = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 uv latched", ctrlBits(), 4'b0010);
    end
    inhibit = 1'b0; drvOk = 1'b1; mainOk = 1'b0;
    @(negedge clk);
    chk("R9 cleared by power cycle", ctrlBits(), 0);
    mainOk = 1'b1; drvOk = 1'b0;
    @(negedge clk);
    chk("R2 clamp after recovery", ctrlBits(), 4'b0100);

    // over-voltage during clamp
    ovDet = 1'b1;
    @(negedge clk);
    chk("R8 ov crowbar", ctrlBits(), 4'b0110);
    ovDet = 1'b0;
    @(negedge clk);
    chk("R9 ov latched", ctrlBits(), 4'b0110);
    mainOk = 1'b0;
    @(negedge clk);
    chk("R9 ov cleared", ctrlBits(), 0);

    // second full sweep with a different target
    targetCode = 8'd255;
    mainOk = 1'b1; drvOk = 1'b1;
    @(negedge clk);
    chk("R2 clamp before second start", ctrlBits(), 4'b0100);
    @(negedge clk);
    chk("R3 second start", ctrlBits(), 4'b1000);
    sweepRamp(255, 1'b0);

    ovDet = 1'b1; uvDet = 1'b1;
    @(negedge clk);
    chk("R8 ov wins over uv", ctrlBits(), 4'b0110);
    ovDet = 1'b0; uvDet = 1'b0; mainOk = 1'b0;
    @(negedge clk);
    chk("R9 cleared", ctrlBits(), 0);

    // inhibit during ramp
    mainOk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 third start", ctrlBits(), 4'b1000);
    repeat (32) @(negedge clk);
    chk("R4 partial ramp", refCode, rampVal(255, 32));
    inhibit = 1'b1; ovDet = 1'b1;
    @(negedge clk);
    chk("R11 inhibit off", ctrlBits(), 0);
    chk("R11 inhibit ref", refCode, 0);
    repeat (2) begin
      @(negedge clk);
      chk("R11 ov ignored", ctrlBits(), 0);
    end
    inhibit = 1'b0; ovDet = 1'b0;
    @(negedge clk);
    chk("R11 release to stop", ctrlBits(), 0);
    @(negedge clk);
    chk("R11 restart clamp", ctrlBits(), 4'b0100);
    @(negedge clk);
    chk("R11 restart ramp", ctrlBits(), 4'b1000);
    chk("R11 ramp from zero", refCode, 0);
    repeat (16) @(negedge clk);
    chk("R4 ramp after restart", refCode, rampVal(255, 16));

    // supply loss during ramp
    drvOk = 1'b0;
    @(negedge clk);
    chk("R10 supply loss stop", ctrlBits(), 0);
    @(negedge clk);
    chk("R10 back to clamp", ctrlBits(), 4'b0100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule